// File: doc/BRIEF.md
# Error-Rate Driven Supply Voltage Controller

This block sets the supply-voltage code that an external regulator follows, closing the loop on observed timing errors rather than on worst-case delay estimates. A pipeline reports each detected and recovered timing error as a one-cycle pulse and each retired instruction as another. The controller measures how many errors occur per window of retired instructions and compares that count with a programmable target. It lowers the code one step when errors are rarer than the target and raises it one step when they are more frequent. As a result, the supply is pushed deliberately below the point where errors first appear and is held where a small, bounded error fraction remains.

The target and window length are both counts, so a target of 3 errors per 1000 retires expresses 0.3 %. Because each error costs a full pipeline recovery, a burst of errors must not wait for the window to close. When the error count inside a window passes an emergency limit, the code jumps up by a programmable larger step on the next clock, and a new window begins. Code value k stands for 0.6 V + k x 10 mV, so codes 0 to 120 cover 0.6 V to 1.8 V in uniform steps. Software-chosen minimum and maximum codes bound the trajectory.

Top module: `err_rate_volt_ctrl`

## Requirements
- R1: While `rstN` is low at a rising clock edge, `voltCode` is loaded with `codeMax`, and the error and retire counts restart from zero.
- R2: A window closes on the rising edge where `retirePulse` is high and it is the `windowLen`-th retire since the window began. Cycles without `retirePulse` do not advance the window, and a `windowLen` of 0 acts as 1.
- R3: At a window close, if the window's error count is below `errTarget`, `voltCode` decreases by one on that edge. An error pulse on the closing cycle counts toward the closing window.
- R4: At a window close, if the window's error count is above `errTarget`, `voltCode` increases by one on that edge.
- R5: At a window close, if the window's error count equals `errTarget`, `voltCode` is unchanged.
- R6: A step down never takes `voltCode` below `codeMin`. At `codeMin`, a low-error window leaves it there.
- R7: A step up never takes `voltCode` above `codeMax`. At `codeMax`, a high-error window leaves it there.
- R8: On the edge where the window's error count, including the current pulse, first exceeds `emergLimit`, `voltCode` becomes min(`voltCode` + `jumpStep`, `codeMax`) without waiting for the window to close. This takes priority over a simultaneous window close.
- R9: An emergency jump starts a new window, with both error and retire counts cleared.
- R10: Outside a window close or an emergency, `voltCode` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| errPulse | input | 1 | One-cycle pulse per recovered timing error |
| retirePulse | input | 1 | One-cycle pulse per retired instruction |
| windowLen | input | CNT_W | Retires per sampling window |
| errTarget | input | CNT_W | Target error count per window |
| emergLimit | input | CNT_W | Error count above which an immediate jump occurs |
| jumpStep | input | CODE_W | Code increment on an emergency |
| codeMin | input | CODE_W | Lowest allowed code |
| codeMax | input | CODE_W | Highest allowed code, and the reset value |
| voltCode | output | CODE_W | Voltage code to the regulator (0.6 V + code x 10 mV) |

## Verification
The hardest situation to reach is an emergency jump followed by a window that must ignore the errors that caused it. To observe the counter clear from the ports, the bench drives a burst of errors with no retires until the jump, then a full window of clean retires. That window must step the code down instead of up. The floor is reached by driving dozens of clean windows from the ceiling, and the ceiling by chaining emergency bursts.

// File: rtl/vctl_pkg.sv
package vctl_pkg;
  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic clearCnt;  // restart window counts
    logic stepDown;  // one code step down
    logic stepUp;    // one code step up
    logic jumpUp;    // emergency jump up
  } ctlStrobe_t;
endpackage

// File: rtl/vctl_control.sv
module vctl_control
  import vctl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             errPulse,
  input  logic             retirePulse,
  input  logic [CNT_W-1:0] retireCnt,
  input  logic [CNT_W-1:0] errCnt,
  input  logic [CNT_W-1:0] windowLen,
  input  logic [CNT_W-1:0] errTarget,
  input  logic [CNT_W-1:0] emergLimit,
  output ctlStrobe_t       strobe
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] errTotal;
  logic [EXT_W-1:0] retireNext;
  logic             winDone;
  logic             emerg;

  always_comb begin
    errTotal   = {1'b0, errCnt} + EXT_W'(errPulse);
    retireNext = {1'b0, retireCnt} + EXT_W'(1);
    winDone    = retirePulse && (retireNext >= {1'b0, windowLen});
    emerg      = errTotal > {1'b0, emergLimit};

    strobe.jumpUp   = emerg;
    strobe.clearCnt = emerg || winDone;
    strobe.stepDown = winDone && !emerg && (errTotal < {1'b0, errTarget});
    strobe.stepUp   = winDone && !emerg && (errTotal > {1'b0, errTarget});
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stepDown, strobe.stepUp, strobe.jumpUp})); // R5
  AST_JUMP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.jumpUp |-> strobe.clearCnt); // R9
  AST_STEP_ON_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDown || strobe.stepUp) |-> retirePulse); // R2
endmodule

// File: rtl/vctl_datapath.sv
module vctl_datapath
  import vctl_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errPulse,
  input  logic              retirePulse,
  input  ctlStrobe_t        strobe,
  input  logic [CODE_W-1:0] jumpStep,
  input  logic [CODE_W-1:0] codeMin,
  input  logic [CODE_W-1:0] codeMax,
  output logic [CNT_W-1:0]  retireCnt,
  output logic [CNT_W-1:0]  errCnt,
  output logic [CODE_W-1:0] voltCode
);
  localparam int SUM_W = CODE_W + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [SUM_W-1:0]  jumpSum;
  logic [CODE_W-1:0] codeNext;

  // window counters
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearCnt) begin
      retireCnt <= '0;
      errCnt    <= '0;
    end else begin
      if (retirePulse && retireCnt != CNT_TOP) retireCnt <= retireCnt + 1'b1;
      if (errPulse && errCnt != CNT_TOP)       errCnt    <= errCnt + 1'b1;
    end
  end

  // code update with saturation
  always_comb begin
    jumpSum  = {1'b0, voltCode} + {1'b0, jumpStep};
    codeNext = voltCode;
    if (strobe.jumpUp) begin
      codeNext = (jumpSum > {1'b0, codeMax}) ? codeMax : jumpSum[CODE_W-1:0];
    end else if (strobe.stepUp) begin
      codeNext = (voltCode < codeMax) ? voltCode + 1'b1 : codeMax;
    end else if (strobe.stepDown) begin
      codeNext = (voltCode > codeMin) ? voltCode - 1'b1 : codeMin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) voltCode <= codeMax;
    else       voltCode <= codeNext;
  end

  AST_RESET_CODE: assert property (@(posedge clk)
    !rstN |=> voltCode == $past(codeMax)); // R1
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDown && voltCode > codeMin) |=> voltCode == $past(voltCode) - 1'b1); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepUp && voltCode < codeMax) |=> voltCode == $past(voltCode) + 1'b1); // R4
  AST_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepDown && voltCode == codeMin) |=> voltCode == $past(codeMin)); // R6
  AST_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.stepUp || strobe.jumpUp) && voltCode <= codeMax) |=> voltCode <= $past(codeMax)); // R7
  AST_NO_IDLE_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.stepDown || strobe.stepUp || strobe.jumpUp) |=> $stable(voltCode)); // R10
  AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCnt |=> (retireCnt == '0 && errCnt == '0)); // R9
endmodule

// File: rtl/err_rate_volt_ctrl.sv
module err_rate_volt_ctrl
  import vctl_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errPulse,
  input  logic              retirePulse,
  input  logic [CNT_W-1:0]  windowLen,
  input  logic [CNT_W-1:0]  errTarget,
  input  logic [CNT_W-1:0]  emergLimit,
  input  logic [CODE_W-1:0] jumpStep,
  input  logic [CODE_W-1:0] codeMin,
  input  logic [CODE_W-1:0] codeMax,
  output logic [CODE_W-1:0] voltCode
);
  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] retireCnt;
  logic [CNT_W-1:0] errCnt;

  vctl_control #(.CNT_W(CNT_W)) uCtl (
    .clk(clk), .rstN(rstN), .errPulse(errPulse), .retirePulse(retirePulse),
    .retireCnt(retireCnt), .errCnt(errCnt), .windowLen(windowLen),
    .errTarget(errTarget), .emergLimit(emergLimit), .strobe(strobe)
  );

  vctl_datapath #(.CNT_W(CNT_W), .CODE_W(CODE_W)) uDp (
    .clk(clk), .rstN(rstN), .errPulse(errPulse), .retirePulse(retirePulse),
    .strobe(strobe), .jumpStep(jumpStep), .codeMin(codeMin), .codeMax(codeMax),
    .retireCnt(retireCnt), .errCnt(errCnt), .voltCode(voltCode)
  );
endmodule

// File: tb/sim_err_rate_volt_ctrl.sv
module sim_err_rate_volt_ctrl;
  localparam int CNT_W  = 16;
  localparam int CODE_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic errPulse = 1'b0;
  logic retirePulse = 1'b0;
  logic [CNT_W-1:0]  windowLen = 16'd10;
  logic [CNT_W-1:0]  errTarget = 16'd2;
  logic [CNT_W-1:0]  emergLimit = 16'd6;
  logic [CODE_W-1:0] jumpStep = 7'd5;
  logic [CODE_W-1:0] codeMin = 7'd10;
  logic [CODE_W-1:0] codeMax = 7'd40;
  logic [CODE_W-1:0] voltCode;

  int nChecks = 0;
  int nErrs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  err_rate_volt_ctrl #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u0 (
    .clk(clk), .rstN(rstN), .errPulse(errPulse), .retirePulse(retirePulse),
    .windowLen(windowLen), .errTarget(errTarget), .emergLimit(emergLimit),
    .jumpStep(jumpStep), .codeMin(codeMin), .codeMax(codeMax), .voltCode(voltCode)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s: voltCode=%0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with given pulses; returns 1 ns after the edge
  task automatic tick(input logic e, input logic r);
    errPulse = e;
    retirePulse = r;
    @(posedge clk);
    #1;
    errPulse = 1'b0;
    retirePulse = 1'b0;
  endtask

  // window of 10 retires, errors on the last nErr retires
  task automatic runWindow(input int nErr);
    for (int i = 0; i < 10; i++) tick(i >= 10 - nErr, 1'b1);
  endtask

  task automatic testReset();
    check("R1 reset to codeMax", voltCode, 40);
  endtask

  task automatic testStepDown();
    for (int i = 0; i < 9; i++) tick(1'b0, 1'b1);
    check("R10 no change mid-window", voltCode, 40);
    tick(1'b0, 1'b1);
    check("R3 clean window steps down", voltCode, 39);
  endtask

  task automatic testHold();
    runWindow(2);  // second error on closing retire
    check("R5 equal errors hold", voltCode, 39);
  endtask

  task automatic testStepUpAndCeiling();
    runWindow(3);
    check("R4 excess errors step up", voltCode, 40);
    runWindow(3);
    check("R7 ceiling holds at codeMax", voltCode, 40);
  endtask

  task automatic testIdleNoAdvance();
    for (int i = 0; i < 9; i++) tick(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b0);
    check("R2 idle cycles do not close window", voltCode, 40);
    tick(1'b0, 1'b1);
    check("R2 tenth retire closes window", voltCode, 39);
  endtask

  task automatic testFloor();
    for (int w = 0; w < 35; w++) runWindow(0);
    check("R6 floor at codeMin", voltCode, 10);
  endtask

  task automatic testEmergency();
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1);
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b0);
    check("R8 no jump at emergLimit", voltCode, 10);
    tick(1'b1, 1'b0);
    check("R8 jump on exceeding emergLimit", voltCode, 15);
    for (int i = 0; i < 9; i++) tick(1'b0, 1'b1);
    check("R9 retire count cleared by jump", voltCode, 15);
    tick(1'b0, 1'b1);
    check("R9 error count cleared by jump", voltCode, 14);
  endtask

  task automatic testJumpSaturate();
    for (int k = 0; k < 6; k++) for (int i = 0; i < 7; i++) tick(1'b1, 1'b0);
    check("R8 R7 jumps saturate at codeMax", voltCode, 40);
  endtask

  task automatic testJumpPriority();
    // 9 retires with errors on the last 6, then closing retire with 7th error
    for (int i = 0; i < 9; i++) tick(i >= 3, 1'b1);
    windowLen = 16'd10;
    codeMax = 7'd60;
    tick(1'b1, 1'b1);
    check("R8 jump wins over window close", voltCode, 45);
    codeMax = 7'd40;
  endtask

  task automatic testZeroWindow();
    windowLen = 16'd0;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    check("R2 zero windowLen acts as one", voltCode, 45);
    tick(1'b0, 1'b1);
    check("R3 zero windowLen clean retire steps down", voltCode, 44);
    windowLen = 16'd10;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    testReset();
    testStepDown();
    testHold();
    testStepUpAndCeiling();
    testIdleNoAdvance();
    testFloor();
    testEmergency();
    testJumpSaturate();
    testJumpPriority();
    testZeroWindow();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nErrs++;
      $display("FAIL watchdog: voltCode=%0d expected run to end", voltCode);
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end
endmodule